// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block decides the operating mode of a single digital PLL channel inside a jitter-attenuating clock generator. It watches whether the currently selected reference is usable, whether phase lock has been reached and whether lock has been lost. From these it steps the channel between four modes: free-run, lock acquisition, locked and holdover. The analog loop, phase detection, input ranking and frequency averaging sit elsewhere and only exchange flags with this controller.

When the selected reference fails, the controller first checks whether any other reference is still flagged usable. If one is, it asks for a switch. If none is, it falls back to holdover, but only when enough reference history has been gathered. Otherwise it falls back to free-run. The history timer counts a prescaled time-base pulse supplied from outside, while the selected reference is good. It stops, without losing its count, whenever the reference is absent.

A software-visible sticky flag records holdover entries. A wide-bandwidth select for fast acquisition follows loss-of-lock automatically when it is enabled. A control bit can force the channel into holdover.

Top module: `csm_mode_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts `mode` at free-run (code 0) and clears `hold_sticky`, `switch_req`, `fast_bw_sel` and the history count. All of these hold on the first edge after `rst` is sampled high.
- R2: Mode codes are free-run 0, lock acquisition 1, locked 2, holdover 3. From free-run, a high `sel_valid` moves the channel to lock acquisition on the next edge.
- R3: From lock acquisition, `phase_locked` high (with `sel_valid` high) moves the channel to locked. From holdover, a high `sel_valid` moves it back to lock acquisition.
- R4: In lock acquisition or locked, a low `sel_valid` while any bit of `in_valid` is high gives `mode` = lock acquisition and a one-cycle `switch_req` pulse on the next edge. While `sel_valid` is low, the `in_valid` bits are taken to describe the other inputs only.
- R5: In lock acquisition or locked, a low `sel_valid` with `in_valid` all zero moves the channel to holdover if history is valid, and to free-run if it is not.
- R6: History becomes valid once the count of cycles with both `tick` and `sel_valid` high reaches (2^`hist_len` − 1) + 2^`hist_dly`. Cycles with `tick` low add nothing.
- R7: When `sel_valid` is low, the history count pauses. It continues from the same value when `sel_valid` returns, and it is not restarted by a fall-back to free-run.
- R8: `fast_bw_sel` is registered and follows `fastlock_en` AND `lol` one cycle later. It drops on the edge after `lol` clears.
- R9: `hold_status` is high exactly when `mode` is free-run or holdover.
- R10: `hold_sticky` sets on every entry into holdover. It clears when `hold_flag_clr` is high in a cycle with no holdover entry. A set and a clear in the same cycle leave it set.
- R11: A high `force_hold` puts the channel in holdover on the next edge from any mode, whatever the history state. It takes priority over every other transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base enable, one history unit per pulse |
| in_valid | input | N_IN | Usable flags of the inputs |
| sel_valid | input | 1 | Selected input is usable |
| phase_locked | input | 1 | Phase lock reached on selected input |
| lol | input | 1 | Loss-of-lock flag |
| force_hold | input | 1 | Force holdover |
| fastlock_en | input | 1 | Enable automatic fast-acquisition bandwidth |
| hist_len | input | 5 | History length exponent |
| hist_dly | input | 5 | History delay exponent |
| hold_flag_clr | input | 1 | Software write of zero to the sticky flag |
| mode | output | 2 | Current mode code |
| hold_status | output | 1 | High in free-run or holdover |
| hold_sticky | output | 1 | Sticky holdover-event flag |
| fast_bw_sel | output | 1 | Fast-acquisition bandwidth select |
| switch_req | output | 1 | One-cycle request to switch input |

## Verification
The fall-back choice is tried with three failure patterns. The first fails with history one tick short of the target. The second fails with history exactly at the target, after a pause in the middle. The third fails while another input is still flagged usable. Together they separate the free-run, holdover and switch outcomes, and they separate a pausing timer from a restarting one. Runs with `tick` held low and a reset in the middle show that only ticked cycles count and that reset discards the history. Forced holdover, sticky clear against entry, and fast-bandwidth follow/drop patterns each cover one remaining control path.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int FIELD_W = 5;
    localparam int HCNT_W  = (1 << FIELD_W) + 1;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_ACQ  = 2'd1,
        MODE_LOCK = 2'd2,
        MODE_HOLD = 2'd3
    } mode_e;

    typedef struct packed {
        logic sel_ok;
        logic alt_ok;
        logic locked;
        logic hist_ok;
        logic force_hold;
    } fsm_in_t;

    // (2^len - 1) + 2^dly time-base units
    function automatic logic [HCNT_W-1:0] hist_target(
        input logic [FIELD_W-1:0] len,
        input logic [FIELD_W-1:0] dly
    );
        logic [HCNT_W-1:0] one;
        one = {{(HCNT_W-1){1'b0}}, 1'b1};
        return ((one << len) - one) + (one << dly);
    endfunction

endpackage

// File: rtl/csm_hist_timer.sv
module csm_hist_timer
    import csm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               sel_valid,
    input  logic [FIELD_W-1:0] len,
    input  logic [FIELD_W-1:0] dly,
    output logic               hist_valid
);
    logic [HCNT_W-1:0] cnt;
    logic [HCNT_W-1:0] target;

    always_comb begin
        target     = hist_target(len, dly);
        hist_valid = (cnt >= target);
    end

    // count only while the reference is good; saturate once valid
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick && sel_valid && !hist_valid) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csm_fastlock.sv
module csm_fastlock (
    input  logic clk,
    input  logic rst,
    input  logic fastlock_en,
    input  logic lol,
    output logic fast_bw_sel
);
    always_ff @(posedge clk) begin
        if (rst) fast_bw_sel <= 1'b0;
        else     fast_bw_sel <= fastlock_en && lol;
    end
endmodule

// File: rtl/csm_mode_fsm.sv
module csm_mode_fsm
    import csm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fsm_in_t fin,
    input  logic    hold_flag_clr,
    output mode_e   mode,
    output logic    switch_req,
    output logic    hold_sticky
);
    mode_e mode_n;
    logic  sw_n;
    logic  fail;

    always_comb begin
        mode_n = mode;
        sw_n   = 1'b0;
        fail   = ((mode == MODE_ACQ) || (mode == MODE_LOCK)) && !fin.sel_ok;
        if (fin.force_hold) begin
            mode_n = MODE_HOLD;
        end else if (fail) begin
            if (fin.alt_ok) begin
                mode_n = MODE_ACQ;
                sw_n   = 1'b1;
            end else if (fin.hist_ok) begin
                mode_n = MODE_HOLD;
            end else begin
                mode_n = MODE_FREE;
            end
        end else begin
            unique case (mode)
                MODE_FREE: if (fin.sel_ok) mode_n = MODE_ACQ;
                MODE_ACQ:  if (fin.locked) mode_n = MODE_LOCK;
                MODE_LOCK: mode_n = MODE_LOCK;
                MODE_HOLD: if (fin.sel_ok) mode_n = MODE_ACQ;
                default:   mode_n = MODE_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MODE_FREE;
            switch_req  <= 1'b0;
            hold_sticky <= 1'b0;
        end else begin
            mode       <= mode_n;
            switch_req <= sw_n;
            if ((mode_n == MODE_HOLD) && (mode != MODE_HOLD)) begin
                hold_sticky <= 1'b1;
            end else if (hold_flag_clr) begin
                hold_sticky <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/csm_mode_ctrl.sv
module csm_mode_ctrl
    import csm_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [N_IN-1:0]    in_valid,
    input  logic               sel_valid,
    input  logic               phase_locked,
    input  logic               lol,
    input  logic               force_hold,
    input  logic               fastlock_en,
    input  logic [FIELD_W-1:0] hist_len,
    input  logic [FIELD_W-1:0] hist_dly,
    input  logic               hold_flag_clr,
    output logic [1:0]         mode,
    output logic               hold_status,
    output logic               hold_sticky,
    output logic               fast_bw_sel,
    output logic               switch_req
);
    logic    hist_valid;
    fsm_in_t fin;
    mode_e   mode_q;

    csm_hist_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .sel_valid  (sel_valid),
        .len        (hist_len),
        .dly        (hist_dly),
        .hist_valid (hist_valid)
    );

    csm_fastlock u_fast (
        .clk         (clk),
        .rst         (rst),
        .fastlock_en (fastlock_en),
        .lol         (lol),
        .fast_bw_sel (fast_bw_sel)
    );

    always_comb begin
        fin.sel_ok     = sel_valid;
        fin.alt_ok     = |in_valid;
        fin.locked     = phase_locked;
        fin.hist_ok    = hist_valid;
        fin.force_hold = force_hold;
    end

    csm_mode_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .fin           (fin),
        .hold_flag_clr (hold_flag_clr),
        .mode          (mode_q),
        .switch_req    (switch_req),
        .hold_sticky   (hold_sticky)
    );

    assign mode        = mode_q;
    assign hold_status = (mode_q == MODE_FREE) || (mode_q == MODE_HOLD);
endmodule

// File: rtl/csm_mode_chk.sv
module csm_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel_valid,
    input logic       force_hold,
    input logic       fastlock_en,
    input logic       lol,
    input logic [1:0] mode,
    input logic       hold_sticky,
    input logic       fast_bw_sel,
    input logic       switch_req,
    input logic       hist_valid
);
    localparam logic [1:0] M_ACQ  = 2'd1;
    localparam logic [1:0] M_LOCK = 2'd2;
    localparam logic [1:0] M_HOLD = 2'd3;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (mode == 2'd0 && !hold_sticky && !switch_req && !fast_bw_sel));

    assert_lock_from_acq_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_LOCK && $past(mode) != M_LOCK) |-> $past(mode) == M_ACQ);

    assert_switch_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        switch_req |-> (mode == M_ACQ && !$past(sel_valid)));

    assert_hold_needs_history_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == M_HOLD && $past(mode) != M_HOLD && !$past(force_hold)) |-> $past(hist_valid));

    assert_fast_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (fastlock_en && lol) |=> fast_bw_sel);

    assert_fast_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !lol |=> !fast_bw_sel);

    assert_sticky_on_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == M_HOLD && $past(mode) != M_HOLD) |-> hold_sticky);

    assert_force_hold_R11: assert property (@(posedge clk) disable iff (rst)
        force_hold |=> mode == M_HOLD);
endmodule

bind csm_mode_ctrl csm_mode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_valid   (sel_valid),
    .force_hold  (force_hold),
    .fastlock_en (fastlock_en),
    .lol         (lol),
    .mode        (mode),
    .hold_sticky (hold_sticky),
    .fast_bw_sel (fast_bw_sel),
    .switch_req  (switch_req),
    .hist_valid  (hist_valid)
);

// File: tb/sim_csm_mode_ctrl.sv
module sim_csm_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN       = 4;
    localparam int NVEC       = 19;

    // [15] sel_valid [14:11] in_valid [10] phase_locked [9] lol [8] force_hold
    // [7] fastlock_en [6] hold_flag_clr | exp [5:4] mode [3] hold_status
    // [2] hold_sticky [1] fast_bw_sel [0] switch_req
    localparam logic [15:0] VEC [NVEC] = '{
        16'b0_0000_0_0_0_0_0_00_1_0_0_0,
        16'b1_0000_0_0_0_0_0_01_0_0_0_0,
        16'b1_0000_0_1_0_1_0_01_0_0_1_0,
        16'b1_0000_1_1_0_0_0_10_0_0_0_0,
        16'b1_0000_1_0_0_1_0_10_0_0_0_0,
        16'b0_0000_0_0_0_0_0_00_1_0_0_0,
        16'b0_0000_0_0_0_0_0_00_1_0_0_0,
        16'b1_0000_0_0_0_0_0_01_0_0_0_0,
        16'b1_0000_1_0_0_0_0_10_0_0_0_0,
        16'b0_0000_0_0_0_0_0_11_1_1_0_0,
        16'b0_0000_0_0_0_0_1_11_1_0_0_0,
        16'b1_0000_0_0_0_0_0_01_0_0_0_0,
        16'b1_0000_1_0_0_0_0_10_0_0_0_0,
        16'b0_0100_0_0_0_0_0_01_0_0_0_1,
        16'b1_0100_0_0_0_0_0_01_0_0_0_0,
        16'b1_0000_0_0_1_0_0_11_1_1_0_0,
        16'b1_0000_0_0_1_0_1_11_1_0_0_0,
        16'b1_0000_0_0_0_0_0_01_0_0_0_0,
        16'b1_0000_1_0_0_0_0_10_0_0_0_0
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            tick;
    logic [N_IN-1:0] in_valid;
    logic            sel_valid, phase_locked, lol, force_hold, fastlock_en;
    logic [4:0]      hist_len, hist_dly;
    logic            hold_flag_clr;
    logic [1:0]      mode;
    logic            hold_status, hold_sticky, fast_bw_sel, switch_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csm_mode_ctrl #(.N_IN(N_IN)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid),
        .sel_valid(sel_valid), .phase_locked(phase_locked), .lol(lol),
        .force_hold(force_hold), .fastlock_en(fastlock_en),
        .hist_len(hist_len), .hist_dly(hist_dly), .hold_flag_clr(hold_flag_clr),
        .mode(mode), .hold_status(hold_status), .hold_sticky(hold_sticky),
        .fast_bw_sel(fast_bw_sel), .switch_req(switch_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [5:0] e);
        chk(req, "mode", int'(mode), int'(e[5:4]));
        chk(req, "hold_status", int'(hold_status), int'(e[3]));
        chk(req, "hold_sticky", int'(hold_sticky), int'(e[2]));
        chk(req, "fast_bw_sel", int'(fast_bw_sel), int'(e[1]));
        chk(req, "switch_req", int'(switch_req), int'(e[0]));
    endtask

    function automatic string vec_req(input int i);
        case (i)
            0:                  return "R9";
            1:                  return "R2";
            2, 4:               return "R8";
            5, 9:               return "R5";
            6, 7:               return "R7";
            10, 16:             return "R10";
            13, 14:             return "R4";
            15:                 return "R11";
            default:            return "R3";
        endcase
    endfunction

    task automatic drive(input logic [9:0] v);
        sel_valid     = v[9];
        in_valid      = v[8:5];
        phase_locked  = v[4];
        lol           = v[3];
        force_hold    = v[2];
        fastlock_en   = v[1];
        hold_flag_clr = v[0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        tick = 1'b1;
        hist_len = 5'd2;   // target (2^2-1)+2^1 = 5 ticks
        hist_dly = 5'd1;
        drive(10'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_all("R1", 6'b00_1_0_0_0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][15:6]);
            @(negedge clk);
            chk_all(vec_req(i), VEC[i][5:0]);
        end

        // R1: reset mid-run from holdover with sticky set clears history too
        drive(10'b0_0000_0_0_1_0_0);
        @(negedge clk);
        chk("R11", "mode", int'(mode), 3);
        rst = 1'b1;
        drive(10'b0);
        @(negedge clk);
        chk_all("R1", 6'b00_1_0_0_0);
        rst = 1'b0;
        // four ticked cycles: one short of target after reset
        drive(10'b1_0000_1_0_0_0_0);
        repeat (4) @(negedge clk);
        chk("R3", "mode", int'(mode), 2);
        // R6: cycles without tick add nothing
        tick = 1'b0;
        repeat (20) @(negedge clk);
        drive(10'b0);
        @(negedge clk);
        chk("R6", "mode", int'(mode), 0);
        chk("R1", "hold_sticky", int'(hold_sticky), 0);
        // R7: one more ticked cycle reaches target exactly, from the kept count
        tick = 1'b1;
        drive(10'b1_0000_0_0_0_0_0);
        @(negedge clk);
        chk("R2", "mode", int'(mode), 1);
        drive(10'b0);
        @(negedge clk);
        chk("R7", "mode", int'(mode), 3);
        chk("R10", "hold_sticky", int'(hold_sticky), 1);
        chk("R9", "hold_status", int'(hold_status), 1);
        // R10: clear in same cycle as an entry leaves flag set
        drive(10'b1_0000_0_0_0_0_1);
        @(negedge clk);
        chk("R10", "hold_sticky", int'(hold_sticky), 0);
        drive(10'b1_0000_0_0_1_0_1);
        @(negedge clk);
        chk("R10", "hold_sticky_entry_vs_clr", int'(hold_sticky), 1);
        drive(10'b0);
        @(negedge clk);
        finish_run();
    end
endmodule